// File: doc/BRIEF.md
# Loop Load Address Predictor

This block sits between a loop-mode load queue and the first-level cache port. It holds one tracker for each load-queue slot. Each tracker watches the address and returned data of every executed instance of its load. It learns whether the load walks memory with a fixed step, a step of zero, or by following the pointer it just read. Once the pattern has been confirmed, the tracker issues a pre-execution request for the next instance. The cache's answer to that request is kept in a small tagged buffer.

When the next instance executes and its address equals the buffered one, the block reports a hit and returns the buffered data one cycle later, so dependent work can wake up early. A confirmed tracker that sees an address other than the one it predicted raises a mispredict pulse instead, and the scheduler replays that load. Any store to a buffered word removes that entry. Dropping loop mode clears all learned state.

Top module: `lp_predictor`

## Requirements
- R1: After reset, and in the cycle after any cycle with `loop_active_i` low, `pre_valid_o`, `hit_o` and `mispredict_o` are 0. Loop exit also empties the result buffer, so a buffered result cached before the exit never produces a hit afterwards.
- R2: Stride pattern. The first two instances of a load set the candidate step (second address minus first). If the third address equals the second address plus that step, the next cycle shows `pre_valid_o`=1 with `pre_idx_o` equal to the load's slot and `pre_addr_o` equal to the third address plus the step.
- R3: Constant pattern. Three instances at the same address confirm a step of zero, and the pre-executed address equals that same address.
- R4: Pointer pattern. If the second address equals the data returned by the first instance, and the third address equals the data returned by the second, the entry locks in pointer mode and pre-executes at the data returned by the third instance. A step match is checked before the pointer match.
- R5: The first two instances of a load never cause a pre-execution. A third instance that matches neither pattern causes none either; it replaces the candidate step with the newest difference, and a fourth instance that fits the new step confirms it.
- R6: Once an entry is confirmed, every instance that matches the prediction issues the next pre-execution (address plus step, or returned data in pointer mode).
- R7: A load whose slot has a filled buffer entry with exactly its address gives `hit_o`=1 and `hit_data_o` equal to the buffered response data in the next cycle. An entry whose response has not yet arrived gives no hit.
- R8: A store whose address matches a buffer entry's address after the low `OFF_W` (default 2) bits are ignored invalidates that entry, so the following load gets no hit. A store to a different word leaves the entry intact.
- R9: A confirmed entry that sees an address other than its prediction raises `mispredict_o` for one cycle, gives no hit, and returns to training. That instance counts as the first new observation, so the pattern must be confirmed again before any further pre-execution.
- R10: Trackers are independent per slot, so loads of different slots interleaved cycle by cycle each learn their own pattern, including a negative step. Buffer entries carry the slot as their tag, and at most one valid entry holds any given tag.
- R11: Loop exit resets all trackers, so an address that would have matched before the exit causes no pre-execution afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_active_i | input | 1 | Loop mode; low clears all trackers and the buffer |
| ld_valid_i | input | 1 | An executed load instance is presented |
| ld_idx_i | input | IDX_W | Load-queue slot of that instance |
| ld_addr_i | input | XLEN | Its address |
| ld_data_i | input | XLEN | Its returned data |
| st_valid_i | input | 1 | A store address is snooped |
| st_addr_i | input | XLEN | Store address |
| rsp_valid_i | input | 1 | Response to a pre-execution request |
| rsp_idx_i | input | IDX_W | Slot the response belongs to |
| rsp_data_i | input | XLEN | Response data |
| pre_valid_o | output | 1 | Pre-execution request pulse |
| pre_idx_o | output | IDX_W | Slot of the request |
| pre_addr_o | output | XLEN | Predicted address |
| hit_o | output | 1 | Previous-cycle load found its result buffered |
| hit_data_o | output | XLEN | Buffered data for that hit |
| mispredict_o | output | 1 | Previous-cycle load broke a confirmed pattern |

## Verification
The assertions check several rules on every cycle. A request or hit only ever follows an observed load. A mispredict never coincides with a hit and always sends its tracker back to training. A snooped store always removes a matching, non-reallocated entry. Buffer tags stay unique, and loop exit silences all outputs. The scenarios are what show the actual predicted addresses for step, zero-step, negative-step and pointer walks, the retraining after a non-matching third instance, the word-granular store snoop, the dependence of hits on response arrival, and the loss of all learned state across a loop exit.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_ONE  = 2'd1,
    TR_TWO  = 2'd2,
    TR_LOCK = 2'd3
  } tr_state_e;

  typedef enum logic {
    MODE_STRIDE = 1'b0,
    MODE_PTR    = 1'b1
  } tr_mode_e;
endpackage

// File: rtl/lp_tracker.sv
module lp_tracker
  import lp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            obs_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] data_i,
  output logic            issue_o,
  output logic [XLEN-1:0] issue_addr_o,
  output logic            mispred_o
);
  tr_state_e       state_q, state_d;
  tr_mode_e        mode_q, mode_d;
  logic            ptr_cand_q, ptr_cand_d;
  logic [XLEN-1:0] last_addr_q, last_data_q, stride_q, stride_d;
  logic [XLEN-1:0] diff, pred_addr;
  logic            stride_ok, ptr_ok;

  assign diff      = addr_i - last_addr_q;
  assign stride_ok = (diff == stride_q);
  assign ptr_ok    = (addr_i == last_data_q);
  assign pred_addr = (mode_q == MODE_PTR) ? last_data_q : last_addr_q + stride_q;

  always_comb begin
    state_d      = state_q;
    mode_d       = mode_q;
    ptr_cand_d   = ptr_cand_q;
    stride_d     = stride_q;
    issue_o      = 1'b0;
    issue_addr_o = '0;
    mispred_o    = 1'b0;
    if (obs_i) begin
      unique case (state_q)
        TR_IDLE: state_d = TR_ONE;
        TR_ONE: begin
          stride_d   = diff;
          ptr_cand_d = ptr_ok;
          state_d    = TR_TWO;
        end
        TR_TWO: begin
          if (stride_ok) begin
            state_d      = TR_LOCK;
            mode_d       = MODE_STRIDE;
            issue_o      = 1'b1;
            issue_addr_o = addr_i + stride_q;
          end else if (ptr_cand_q && ptr_ok) begin
            state_d      = TR_LOCK;
            mode_d       = MODE_PTR;
            issue_o      = 1'b1;
            issue_addr_o = data_i;
          end else begin
            stride_d   = diff;
            ptr_cand_d = ptr_ok;
          end
        end
        TR_LOCK: begin
          if (addr_i == pred_addr) begin
            issue_o      = 1'b1;
            issue_addr_o = (mode_q == MODE_PTR) ? data_i : addr_i + stride_q;
          end else begin
            mispred_o  = 1'b1;
            state_d    = TR_ONE;
            ptr_cand_d = 1'b0;
          end
        end
        default: state_d = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TR_IDLE;
      mode_q      <= MODE_STRIDE;
      ptr_cand_q  <= 1'b0;
      stride_q    <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else if (clr_i) begin
      state_q    <= TR_IDLE;
      mode_q     <= MODE_STRIDE;
      ptr_cand_q <= 1'b0;
      stride_q   <= '0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      ptr_cand_q <= ptr_cand_d;
      stride_q   <= stride_d;
      if (obs_i) begin
        last_addr_q <= addr_i;
        last_data_q <= data_i;
      end
    end
  end

  // R9
  mispred_retrain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_o && !clr_i |=> state_q == TR_ONE);

  // R5
  issue_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && !clr_i |=> state_q == TR_LOCK);
endmodule

// File: rtl/lp_prebuf.sv
module lp_prebuf #(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 3,
  parameter int PB_DEPTH = 4,
  parameter int OFF_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             lk_valid_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [XLEN-1:0]  lk_addr_i,
  output logic             lk_hit_o,
  output logic [XLEN-1:0]  lk_data_o,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic [XLEN-1:0]  alloc_addr_i,
  input  logic             st_valid_i,
  input  logic [XLEN-1:0]  st_addr_i,
  input  logic             rsp_valid_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  input  logic [XLEN-1:0]  rsp_data_i
);
  localparam int PB_W = (PB_DEPTH > 1) ? $clog2(PB_DEPTH) : 1;

  logic [PB_DEPTH-1:0] valid_q, filled_q, tag_match, lk_match;
  logic [IDX_W-1:0]    tag_q  [PB_DEPTH];
  logic [XLEN-1:0]     addr_q [PB_DEPTH];
  logic [XLEN-1:0]     data_q [PB_DEPTH];
  logic [PB_W-1:0]     victim_q, sel;
  logic                found, use_victim;

  always_comb begin
    sel   = victim_q;
    found = 1'b0;
    for (int i = 0; i < PB_DEPTH; i++) begin
      if (!found && tag_match[i]) begin
        sel   = PB_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < PB_DEPTH; i++) begin
      if (!found && !valid_q[i]) begin
        sel   = PB_W'(i);
        found = 1'b1;
      end
    end
    use_victim = !found;
  end

  always_comb begin
    lk_data_o = '0;
    for (int i = 0; i < PB_DEPTH; i++) begin
      if (lk_match[i]) lk_data_o = lk_data_o | data_q[i];
    end
  end
  assign lk_hit_o = |lk_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) victim_q <= '0;
    else if (clr_i) victim_q <= '0;
    else if (alloc_i && use_victim)
      victim_q <= (victim_q == PB_W'(PB_DEPTH - 1)) ? '0 : victim_q + 1'b1;
  end

  for (genvar e = 0; e < PB_DEPTH; e++) begin : g_ent
    logic alloc_e, st_hit_e, use_e, fill_e;
    assign tag_match[e] = valid_q[e] && (tag_q[e] == alloc_idx_i);
    assign alloc_e  = alloc_i && (sel == PB_W'(e));
    assign st_hit_e = st_valid_i && valid_q[e] &&
                      (addr_q[e][XLEN-1:OFF_W] == st_addr_i[XLEN-1:OFF_W]);
    assign use_e    = lk_valid_i && valid_q[e] && (tag_q[e] == lk_idx_i);
    assign fill_e   = rsp_valid_i && valid_q[e] && !filled_q[e] && (tag_q[e] == rsp_idx_i);
    assign lk_match[e] = use_e && filled_q[e] && (addr_q[e] == lk_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e]  <= 1'b0;
        filled_q[e] <= 1'b0;
        tag_q[e]    <= '0;
        addr_q[e]   <= '0;
        data_q[e]   <= '0;
      end else if (clr_i) begin
        valid_q[e]  <= 1'b0;
        filled_q[e] <= 1'b0;
      end else if (alloc_e) begin
        valid_q[e]  <= 1'b1;
        filled_q[e] <= 1'b0;
        tag_q[e]    <= alloc_idx_i;
        addr_q[e]   <= alloc_addr_i;
      end else if (st_hit_e || use_e) begin
        valid_q[e]  <= 1'b0;
        filled_q[e] <= 1'b0;
      end else if (fill_e) begin
        filled_q[e] <= 1'b1;
        data_q[e]   <= rsp_data_i;
      end
    end

    // R8
    st_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_hit_e && !alloc_e && !clr_i |=> !valid_q[e]);
  end

  // R10
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tag_match));
endmodule

// File: rtl/lp_predictor.sv
module lp_predictor #(
  parameter int XLEN     = 32,
  parameter int NUM_LD   = 8,
  parameter int PB_DEPTH = 4,
  parameter int OFF_W    = 2,
  localparam int IDX_W   = (NUM_LD > 1) ? $clog2(NUM_LD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_active_i,
  input  logic             ld_valid_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  input  logic             st_valid_i,
  input  logic [XLEN-1:0]  st_addr_i,
  input  logic             rsp_valid_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  input  logic [XLEN-1:0]  rsp_data_i,
  output logic             pre_valid_o,
  output logic [IDX_W-1:0] pre_idx_o,
  output logic [XLEN-1:0]  pre_addr_o,
  output logic             hit_o,
  output logic [XLEN-1:0]  hit_data_o,
  output logic             mispredict_o
);
  logic              clr, ld_obs;
  logic [NUM_LD-1:0] trk_issue, trk_mis;
  logic [XLEN-1:0]   trk_addr [NUM_LD];
  logic              any_issue, lk_hit;
  logic [XLEN-1:0]   lk_data;

  assign clr    = !loop_active_i;
  assign ld_obs = ld_valid_i && loop_active_i;

  for (genvar t = 0; t < NUM_LD; t++) begin : g_trk
    lp_tracker #(.XLEN(XLEN)) i_trk (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr),
      .obs_i        (ld_obs && (ld_idx_i == IDX_W'(t))),
      .addr_i       (ld_addr_i),
      .data_i       (ld_data_i),
      .issue_o      (trk_issue[t]),
      .issue_addr_o (trk_addr[t]),
      .mispred_o    (trk_mis[t])
    );
  end

  assign any_issue = |trk_issue;

  lp_prebuf #(
    .XLEN(XLEN), .IDX_W(IDX_W), .PB_DEPTH(PB_DEPTH), .OFF_W(OFF_W)
  ) i_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .lk_valid_i   (ld_obs),
    .lk_idx_i     (ld_idx_i),
    .lk_addr_i    (ld_addr_i),
    .lk_hit_o     (lk_hit),
    .lk_data_o    (lk_data),
    .alloc_i      (any_issue),
    .alloc_idx_i  (ld_idx_i),
    .alloc_addr_i (trk_addr[ld_idx_i]),
    .st_valid_i   (st_valid_i && loop_active_i),
    .st_addr_i    (st_addr_i),
    .rsp_valid_i  (rsp_valid_i && loop_active_i),
    .rsp_idx_i    (rsp_idx_i),
    .rsp_data_i   (rsp_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_valid_o  <= 1'b0;
      pre_idx_o    <= '0;
      pre_addr_o   <= '0;
      hit_o        <= 1'b0;
      hit_data_o   <= '0;
      mispredict_o <= 1'b0;
    end else begin
      pre_valid_o  <= any_issue;
      pre_idx_o    <= ld_idx_i;
      pre_addr_o   <= trk_addr[ld_idx_i];
      hit_o        <= lk_hit;
      hit_data_o   <= lk_data;
      mispredict_o <= |trk_mis;
    end
  end

  // R1
  exit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_active_i |=> !pre_valid_o && !hit_o && !mispredict_o);

  // R6
  req_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_issue |=> pre_valid_o && $past(ld_valid_i && loop_active_i));

  // R7
  hit_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit |=> hit_o && $past(ld_valid_i));

  // R9
  mis_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> !hit_o);
endmodule

// File: tb/test_lp_predictor.sv
`timescale 1ns/1ps
module test_lp_predictor;
  localparam int XLEN = 32;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_active = 1'b0;
  logic ld_valid = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [XLEN-1:0] ld_addr = '0, ld_data = '0;
  logic st_valid = 1'b0;
  logic [XLEN-1:0] st_addr = '0;
  logic rsp_valid = 1'b0;
  logic [IDX_W-1:0] rsp_idx = '0;
  logic [XLEN-1:0] rsp_data = '0;
  logic pre_valid, hit, mis;
  logic [IDX_W-1:0] pre_idx;
  logic [XLEN-1:0] pre_addr, hit_data;

  int checks = 0, fails = 0, cyc = 0;
  bit mon_en = 1'b0;

  typedef struct {
    int cyc;
    bit pv;
    logic [IDX_W-1:0] pidx;
    logic [XLEN-1:0] paddr;
    bit hit;
    logic [XLEN-1:0] hdata;
    bit mis;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lp_predictor i_lp_predictor (
    .clk_i(clk), .rst_ni(rst_n), .loop_active_i(loop_active),
    .ld_valid_i(ld_valid), .ld_idx_i(ld_idx), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .st_valid_i(st_valid), .st_addr_i(st_addr),
    .rsp_valid_i(rsp_valid), .rsp_idx_i(rsp_idx), .rsp_data_i(rsp_data),
    .pre_valid_o(pre_valid), .pre_idx_o(pre_idx), .pre_addr_o(pre_addr),
    .hit_o(hit), .hit_data_o(hit_data), .mispredict_o(mis)
  );

  task automatic compare(exp_t e);
    bit ok;
    ok = (pre_valid == e.pv) && (hit == e.hit) && (mis == e.mis);
    if (e.pv)  ok = ok && (pre_idx == e.pidx) && (pre_addr == e.paddr);
    if (e.hit) ok = ok && (hit_data == e.hdata);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got pv=%0b idx=%0d addr=%h hit=%0b data=%h mis=%0b exp pv=%0b idx=%0d addr=%h hit=%0b data=%h mis=%0b",
               e.req, pre_valid, pre_idx, pre_addr, hit, hit_data, mis,
               e.pv, e.pidx, e.paddr, e.hit, e.hdata, e.mis);
    end
  endtask

  // monitor: results appear one edge after the stimulus
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc - 1) begin
        compare(exp_q.pop_front());
      end else begin
        exp_t idle;
        idle = '{cyc: 0, pv: 0, pidx: '0, paddr: '0, hit: 0, hdata: '0, mis: 0, req: "idle R1"};
        compare(idle);
      end
    end
  end

  task automatic ld(input int idx, input logic [XLEN-1:0] a, input logic [XLEN-1:0] d,
                    input bit pv, input logic [XLEN-1:0] pa, input bit h,
                    input logic [XLEN-1:0] hd, input bit m, input string req);
    exp_t e;
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = IDX_W'(idx); ld_addr = a; ld_data = d;
    e = '{cyc: cyc, pv: pv, pidx: IDX_W'(idx), paddr: pa, hit: h, hdata: hd, mis: m, req: req};
    exp_q.push_back(e);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic rsp(input int idx, input logic [XLEN-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_idx = IDX_W'(idx); rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic st(input logic [XLEN-1:0] a);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got no finish, exp finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (pre_valid || hit || mis) begin
      fails++;
      $display("FAIL R1 reset: got pv=%0b hit=%0b mis=%0b exp 0 0 0", pre_valid, hit, mis);
    end
    rst_n = 1'b1;
    @(negedge clk);
    loop_active = 1'b1;
    mon_en = 1'b1;

    // R2 stride, R5 no issue on first two
    ld(1, 32'h1000, 32'h1, 0, 0, 0, 0, 0, "R5 first");
    ld(1, 32'h1010, 32'h2, 0, 0, 0, 0, 0, "R5 second");
    ld(1, 32'h1020, 32'h3, 1, 32'h1030, 0, 0, 0, "R2 verify");
    rsp(1, 32'hAAAA);
    ld(1, 32'h1030, 32'hAAAA, 1, 32'h1040, 1, 32'hAAAA, 0, "R7 hit R6");
    ld(1, 32'h1040, 32'h5, 1, 32'h1050, 0, 0, 0, "R7 unfilled");
    rsp(1, 32'hBBBB);
    st(32'h1052);
    ld(1, 32'h1050, 32'h6, 1, 32'h1060, 0, 0, 0, "R8 store kill");
    rsp(1, 32'hCCCC);
    st(32'h1064);
    ld(1, 32'h1060, 32'hCCCC, 1, 32'h1070, 1, 32'hCCCC, 0, "R8 other word");
    // R9 mispredict and retraining
    ld(1, 32'h2000, 32'h7, 0, 0, 0, 0, 1, "R9 mispredict");
    ld(1, 32'h2008, 32'h8, 0, 0, 0, 0, 0, "R9 retrain");
    ld(1, 32'h2010, 32'h9, 1, 32'h2018, 0, 0, 0, "R9 relock");

    // R3 constant
    ld(2, 32'h3000, 32'h11, 0, 0, 0, 0, 0, "R3 first");
    ld(2, 32'h3000, 32'h11, 0, 0, 0, 0, 0, "R3 second");
    ld(2, 32'h3000, 32'h11, 1, 32'h3000, 0, 0, 0, "R3 verify");
    rsp(2, 32'h55);
    ld(2, 32'h3000, 32'h55, 1, 32'h3000, 1, 32'h55, 0, "R3 hit");

    // R4 pointer chase
    ld(3, 32'h4000, 32'h4100, 0, 0, 0, 0, 0, "R4 first");
    ld(3, 32'h4100, 32'h4140, 0, 0, 0, 0, 0, "R4 second");
    ld(3, 32'h4140, 32'h4400, 1, 32'h4400, 0, 0, 0, "R4 verify");
    ld(3, 32'h4400, 32'h4500, 1, 32'h4500, 0, 0, 0, "R4 R6 follow");

    // R5 non-matching third
    ld(4, 32'h5000, 32'h0, 0, 0, 0, 0, 0, "R5 a");
    ld(4, 32'h5010, 32'h0, 0, 0, 0, 0, 0, "R5 b");
    ld(4, 32'h5030, 32'h0, 0, 0, 0, 0, 0, "R5 no match");
    ld(4, 32'h5050, 32'h0, 1, 32'h5070, 0, 0, 0, "R5 new step");

    // R10 interleaved slots, negative step
    ld(5, 32'h6000, 32'h0, 0, 0, 0, 0, 0, "R10 s5 a");
    ld(6, 32'h7000, 32'h0, 0, 0, 0, 0, 0, "R10 s6 a");
    ld(5, 32'h6004, 32'h0, 0, 0, 0, 0, 0, "R10 s5 b");
    ld(6, 32'h6FFC, 32'h0, 0, 0, 0, 0, 0, "R10 s6 b");
    ld(5, 32'h6008, 32'h0, 1, 32'h600C, 0, 0, 0, "R10 s5 lock");
    ld(6, 32'h6FF8, 32'h0, 1, 32'h6FF4, 0, 0, 0, "R10 s6 lock");

    // R1 / R11 loop exit
    ld(2, 32'h3000, 32'h55, 1, 32'h3000, 0, 0, 0, "R3 again");
    rsp(2, 32'h66);
    ld(2, 32'h3000, 32'h66, 1, 32'h3000, 1, 32'h66, 0, "R7 before exit");
    rsp(2, 32'h77);
    @(negedge clk);
    loop_active = 1'b0;
    @(negedge clk);
    loop_active = 1'b1;
    ld(2, 32'h3000, 32'h77, 0, 0, 0, 0, 0, "R1 buffer cleared");
    ld(1, 32'h2018, 32'h0, 0, 0, 0, 0, 0, "R11 tracker cleared");

    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: got %0d left, exp 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule